// File: doc/BRIEF.md
# Cascadable presettable synchronous counter

This block is a binary up-counter built from identical narrow slices, each 4 bits wide by default. Every slice has the same controls:
- a synchronous active-low clear;
- a synchronous active-low parallel load from its share of a data bus;
- two count enables;
- a terminal-count output that is high when the slice is all ones and its carry enable is high.

The top level chains a parameterised number of slices into one wider counter. Each slice's terminal count drives the carry enable of the slice above it. One external enable feeds the lowest slice's carry enable, and a second enable is shared by every slice.

All state changes happen on the rising clock edge, with this priority:
1. Reset.
2. Clear.
3. Load.
4. Count.

The overall terminal count comes from the last slice. It is combinational, so it is valid in the same cycle and can drive a further counter stage without extra logic.

Top module: `casc_counter`

## Requirements
- R1: When `rst` is high at a rising edge, `count` becomes zero after that edge, whatever the other inputs are.
- R2: When `rst` is low and `clear_n` is low at a rising edge, `count` becomes zero after that edge, whatever the levels of `load_n`, `cnt_en` and `carry_en`.
- R3: When `rst` is low, `clear_n` is high and `load_n` is low at a rising edge, `count` takes the value of `load_data` after that edge, whatever the levels of both enables.
- R4: When `rst` is low, `clear_n` and `load_n` are high, and `cnt_en` and `carry_en` are both high, `count` increments by one at the edge. The count is straight binary with bit 0 as the least significant bit, and carries propagate across slice boundaries on the same edge. For example, 0x0FF becomes 0x100.
- R5: When `rst` is low, `clear_n` and `load_n` are high, and either `cnt_en` or `carry_en` is low, `count` holds its value across the edge.
- R6: An enabled increment from the all-ones value wraps `count` to zero.
- R7: `term_cnt` is high exactly when `carry_en` is high and every bit of `count` is one, in the same cycle and independent of `cnt_en`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| clear_n | input | 1 | Synchronous clear, active low |
| load_n | input | 1 | Synchronous parallel load, active low |
| load_data | input | SLICE_W*N_SLICES | Value copied into the counter on a load |
| cnt_en | input | 1 | Count enable shared by all slices |
| carry_en | input | 1 | Carry enable of the lowest slice; also gates the terminal count |
| count | output | SLICE_W*N_SLICES | Registered counter value, bit 0 least significant |
| term_cnt | output | 1 | High when the count is all ones and carry_en is high |

## Verification
The value of `count` is due one rising edge after the controls are applied. The bench drives inputs on a falling edge, updates its reference model once per rising edge, and compares `count` at the following falling edge. `term_cnt` is combinational, so it is due in the cycle in which the inputs are applied. The bench checks it 1 ns after driving, against the model value held since the last edge.

// File: rtl/casc_pkg.sv
package casc_pkg;
  typedef enum logic [1:0] {
    OP_HOLD  = 2'd0,
    OP_INC   = 2'd1,
    OP_LOAD  = 2'd2,
    OP_CLEAR = 2'd3
  } slice_op_e;
endpackage

// File: rtl/casc_slice_ctl.sv
module casc_slice_ctl
  import casc_pkg::*;
(
  input  logic      rst,
  input  logic      clear_n,
  input  logic      load_n,
  input  logic      en_p,
  input  logic      en_t,
  output slice_op_e op
);
  // Priority: reset, then clear, then load, then count.
  always_comb begin
    if (rst || !clear_n)     op = OP_CLEAR;
    else if (!load_n)        op = OP_LOAD;
    else if (en_p && en_t)   op = OP_INC;
    else                     op = OP_HOLD;
  end
endmodule

// File: rtl/casc_slice.sv
module casc_slice
  import casc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         clear_n,
  input  logic         load_n,
  input  logic         en_p,
  input  logic         en_t,
  input  logic [W-1:0] d,
  output logic [W-1:0] q,
  output logic         tc
);
  slice_op_e   op;
  logic [W-1:0] q_r;

  casc_slice_ctl ctl_i (
    .rst     (rst),
    .clear_n (clear_n),
    .load_n  (load_n),
    .en_p    (en_p),
    .en_t    (en_t),
    .op      (op)
  );

  always_ff @(posedge clk) begin
    case (op)
      OP_CLEAR: q_r <= '0;
      OP_LOAD:  q_r <= d;
      OP_INC:   q_r <= q_r + 1'b1;
      default:  q_r <= q_r;
    endcase
  end

  assign q  = q_r;
  assign tc = en_t & (&q_r);

  // R1: reset clears the slice
  a_r1_reset: assert property (@(posedge clk) rst |=> (q_r == '0));
  // R2: clear beats load and count
  a_r2_clear: assert property (@(posedge clk) disable iff (rst)
    !clear_n |=> (q_r == '0));
  // R3: load beats count
  a_r3_load: assert property (@(posedge clk) disable iff (rst)
    (clear_n && !load_n) |=> (q_r == $past(d)));
  // R4: enabled increment
  a_r4_inc: assert property (@(posedge clk) disable iff (rst)
    (clear_n && load_n && en_p && en_t) |=> (q_r == W'($past(q_r) + 1'b1)));
  // R5: hold when an enable is low
  a_r5_hold: assert property (@(posedge clk) disable iff (rst)
    (clear_n && load_n && !(en_p && en_t)) |=> $stable(q_r));
endmodule

// File: rtl/casc_counter.sv
module casc_counter #(
  parameter int SLICE_W  = 4,
  parameter int N_SLICES = 3
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        clear_n,
  input  logic                        load_n,
  input  logic [SLICE_W*N_SLICES-1:0] load_data,
  input  logic                        cnt_en,
  input  logic                        carry_en,
  output logic [SLICE_W*N_SLICES-1:0] count,
  output logic                        term_cnt
);
  localparam int TOTAL_W = SLICE_W * N_SLICES;

  logic [N_SLICES:0] chain;
  assign chain[0] = carry_en;

  for (genvar i = 0; i < N_SLICES; i++) begin : g_slice
    casc_slice #(.W(SLICE_W)) slice_i (
      .clk     (clk),
      .rst     (rst),
      .clear_n (clear_n),
      .load_n  (load_n),
      .en_p    (cnt_en),
      .en_t    (chain[i]),
      .d       (load_data[i*SLICE_W +: SLICE_W]),
      .q       (count[i*SLICE_W +: SLICE_W]),
      .tc      (chain[i+1])
    );
  end

  assign term_cnt = chain[N_SLICES];

  // R7: terminal count of the whole chain
  a_r7_term: assert property (@(posedge clk) disable iff (rst)
    term_cnt == (carry_en && (count == {TOTAL_W{1'b1}})));
  // R6: wrap from all ones across every slice
  a_r6_wrap: assert property (@(posedge clk) disable iff (rst)
    (clear_n && load_n && cnt_en && carry_en && (count == {TOTAL_W{1'b1}}))
      |=> (count == '0));
  // R4: carry crosses slice boundaries on the same edge
  a_r4_wide_inc: assert property (@(posedge clk) disable iff (rst)
    (clear_n && load_n && cnt_en && carry_en)
      |=> (count == TOTAL_W'($past(count) + 1'b1)));
endmodule

// File: tb/casc_counter_tb_top.sv
module casc_counter_tb_top;
  localparam int W  = 4;
  localparam int N  = 3;
  localparam int TW = W * N;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst = 1'b1, clear_n = 1'b1, load_n = 1'b1;
  logic          cnt_en = 1'b0, carry_en = 1'b0;
  logic [TW-1:0] load_data = '0;
  logic [TW-1:0] count;
  logic          term_cnt;

  int n_run = 0, n_fail = 0;
  logic [TW-1:0] model = '0;

  casc_counter #(.SLICE_W(W), .N_SLICES(N)) dut_i (
    .clk(clk), .rst(rst), .clear_n(clear_n), .load_n(load_n),
    .load_data(load_data), .cnt_en(cnt_en), .carry_en(carry_en),
    .count(count), .term_cnt(term_cnt)
  );

  function automatic logic [TW-1:0] next_val(logic [TW-1:0] cur, logic r,
      logic c, logic l, logic e, logic ce, logic [TW-1:0] d);
    if (r || !c)   return '0;
    if (!l)        return d;
    if (e && ce)   return cur + 1'b1;
    return cur;
  endfunction

  function automatic string req_of(logic [TW-1:0] cur, logic r, logic c,
      logic l, logic e, logic ce);
    if (r)        return "R1";
    if (!c)       return "R2";
    if (!l)       return "R3";
    if (e && ce)  return (&cur) ? "R6" : "R4";
    return "R5";
  endfunction

  task automatic check(string req, logic [TW-1:0] act, logic [TW-1:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Called at a falling edge: drive, check term_cnt, then check count after the edge.
  task automatic cycle(logic r, logic c, logic l, logic e, logic ce,
      logic [TW-1:0] d);
    string req;
    rst = r; clear_n = c; load_n = l; cnt_en = e; carry_en = ce; load_data = d;
    #1;
    check("R7", TW'(term_cnt), TW'((&model) && ce));
    req   = req_of(model, r, c, l, e, ce);
    model = next_val(model, r, c, l, e, ce, d);
    @(posedge clk);
    @(negedge clk);
    check(req, count, model);
  endtask

  initial begin
    #(200000 * 20);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'd2468));
    @(negedge clk);
    cycle(1, 0, 0, 1, 1, 12'hABC);                  // R1 reset beats all
    cycle(0, 1, 0, 1, 1, 12'h5A5);                  // R3 load beats count
    cycle(0, 0, 0, 1, 1, 12'h777);                  // R2 clear beats load
    cycle(0, 1, 0, 0, 0, 12'h0FF);                  // R3 load with enables low
    cycle(0, 1, 1, 1, 1, 12'h000);                  // R4 carry into upper slice
    cycle(0, 1, 1, 0, 1, 12'h000);                  // R5 hold, cnt_en low
    cycle(0, 1, 1, 1, 0, 12'h000);                  // R5 hold, carry_en low
    cycle(0, 1, 0, 1, 1, 12'h0FE);                  // R3
    cycle(0, 1, 1, 1, 1, 12'h000);                  // R4 to 0x0FF
    cycle(0, 1, 1, 1, 1, 12'h000);                  // R4 to 0x100
    cycle(0, 1, 0, 0, 1, 12'hFFF);                  // R3 load all ones
    cycle(0, 1, 1, 0, 1, 12'h000);                  // R7 high with cnt_en low
    cycle(0, 1, 1, 0, 0, 12'h000);                  // R7 low with carry_en low
    cycle(0, 1, 1, 1, 1, 12'h000);                  // R6 wrap to zero
    cycle(0, 1, 0, 1, 1, 12'hFFF);
    cycle(0, 0, 1, 1, 1, 12'h000);                  // R2 clear beats count
    for (int k = 0; k < 4000; k++) begin
      logic r, c, l, e, ce;
      logic [TW-1:0] d;
      r  = ($urandom_range(99) < 2);
      c  = ($urandom_range(99) >= 4);
      l  = ($urandom_range(99) >= 8);
      e  = ($urandom_range(99) >= 15);
      ce = ($urandom_range(99) >= 15);
      d  = ($urandom_range(3) == 0) ? {TW{1'b1}} - TW'($urandom_range(3))
                                    : TW'($urandom);
      cycle(r, c, l, e, ce, d);
    end
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule